// File: doc/BRIEF.md
# Short-Descriptor Access Permission Checker

This block decides whether one memory access may proceed under a translation entry that has already been found. It does no lookup and no address reporting. Each cycle the caller presents the entry's attributes, what the access is and the current control state. The block returns a registered verdict one cycle later: either a grant, or a fault type together with two attribution flags. One flag says whether the fault is raised on the instruction side. The other says whether it is attributed to the second translation stage.

The verdict is the result of one priority chain. Cache maintenance comes first and always wins. After it come, in order: the page-table-walk memory-type check, the alignment check for non-Normal memory, the prefetch-to-uncacheable check, the domain lookup, and the permission stage. The permission stage combines three things: the re-encoded access-permission value, the hypervisor read/write bits, and a derived execute-never.

Top module: `sdesc_perm_check`

## Requirements
- R1: During reset and on the first clock after it, resValid, resGrant, resFault, resInstSide and resStage2 are all 0.
- R2: A request sampled at a rising edge with reqValid=1 produces its verdict on the outputs after that edge, with resValid=1. A cycle with reqValid=0 drives resValid to 0 and holds resGrant, resFault, resInstSide and resStage2 at their previous values.
- R3: A request with reqCacheMaint=1 is always granted, whatever its other inputs are.
- R4: A request with cfgStage2=1, reqPtWalk=1 and cfgPtwCheck=1 faults when entMemType is not 0 (0 = Normal; 1, 2 and 3 are non-Normal). The fault is permission (code 3), data side, with resStage2=1.
- R5: A read or write (reqKind 0 = read, 1 = write, 3 = read; 2 = fetch) to non-Normal memory faults with alignment (code 1) when reqAddrLow has any bit set below bit reqSizeLog2. A fetch and an access to Normal memory are exempt. resStage2 equals cfgStage2.
- R6: reqPrefetch=1 together with entNonCache=1 gives prefetch-uncacheable (code 4), with resInstSide=1.
- R7: For a short-format entry, the 2-bit field of cfgDomainAccess at bits [2·entDomain+1 : 2·entDomain] is decoded as follows. Values 0 and 2 give a domain fault (code 2, resInstSide = fetch). Value 3 grants without any permission check. Value 1 continues to the permission stage. A long-format entry skips the domain decode entirely.
- R8: The effective 3-bit AP value is entAp for the short format, and {entAp[1:0],0} for the long format. Bit 0 is forced to 1 when the format is long or cfgAfe=1. For a first-stage request, the AP-stage abort is decided by this value:
  - 0: depends on cfgLegacyRs. With 1 it aborts on a write or an unprivileged access. With 2 it aborts on a write. With 0 or 3 it always aborts.
  - 1: aborts when unprivileged.
  - 2: aborts on an unprivileged write.
  - 3: never aborts.
  - 4: always aborts.
  - 5: aborts on a write or an unprivileged access.
  - 6 and 7: abort on a write.
- R9: With cfgStage2=1 the AP check is skipped. For every request, a write aborts when entHap[1]=0, and a read or fetch aborts when entHap[0]=0.
- R10: Execute-never is set when any of these holds: entXn is set; the page is writable and cfgWxn is set; or the AP value is 3, cfgUwxn is set and the access is privileged. The page is not writable for AP values 5, 6 and 7, for AP 2 when unprivileged, and for AP 0 under cfgLegacyRs 1 or 2. A fetch faults as permission with resInstSide=1 on any of: an AP abort; execute-never; long format with entPxn set on a privileged fetch; or reqSecure=1, entNonSecure=1 and cfgSif=1.
- R11: A permission fault that is not a fetch fault (an AP or hypervisor abort) reports resInstSide=0. It reports resStage2=1 when cfgStage2=1 or when the AP stage did not abort. resGrant is 1 exactly when resFault is 0.
- R12: When several fault conditions hold together, the reported fault is the first one in this order: page-table-walk check, alignment, prefetch-uncacheable, domain, permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| reqPriv | input | 1 | Privileged access |
| reqSecure | input | 1 | Access made from the secure state |
| reqPrefetch | input | 1 | Access is a prefetch |
| reqCacheMaint | input | 1 | Cache maintenance by address |
| reqPtWalk | input | 1 | Access belongs to a first-stage table walk |
| reqAddrLow | input | ADDR_LSB_W (6) | Low address bits |
| reqSizeLog2 | input | SIZE_W (3) | log2 of the access size in bytes |
| entDomain | input | DOM_IDX_W (4) | Entry domain number |
| entAp | input | 3 | Entry access-permission bits |
| entHap | input | 2 | Hypervisor permission: bit 1 write, bit 0 read |
| entXn | input | 1 | Entry execute-never |
| entPxn | input | 1 | Entry privileged execute-never (long format) |
| entMemType | input | 2 | 0 Normal, 1 Device, 2 strongly ordered, 3 reserved |
| entNonCache | input | 1 | Entry is non-cacheable |
| entLongFmt | input | 1 | Entry uses the long descriptor format |
| entNonSecure | input | 1 | Entry maps a non-secure page |
| cfgDomainAccess | input | 2·NUM_DOMAINS (32) | Per-domain 2-bit access control |
| cfgWxn | input | 1 | Writable implies execute-never |
| cfgUwxn | input | 1 | Fully accessible implies privileged execute-never |
| cfgAfe | input | 1 | Simplified AP model (forces AP bit 0) |
| cfgSif | input | 1 | Secure fetch from non-secure pages forbidden |
| cfgLegacyRs | input | 2 | Legacy system/ROM protection select for AP 0 |
| cfgPtwCheck | input | 1 | Enable memory-type check on walk accesses |
| cfgStage2 | input | 1 | This is a second-stage check |
| resValid | output | 1 | Verdict valid |
| resGrant | output | 1 | Access allowed |
| resFault | output | 3 | 0 none, 1 alignment, 2 domain, 3 permission, 4 prefetch-uncacheable |
| resInstSide | output | 1 | Fault raised on the instruction side |
| resStage2 | output | 1 | Fault attributed to the second stage |

## Verification
The verdict register is the only state on the datapath. A wrong value in it is therefore visible at the ports on the very cycle after the request. That applies to a stale capture, a missed capture, or a result lost during an idle cycle. Faults in the decode show up the same way: a domain field read from the wrong position, a mis-ranked priority, or a wrong AP row each yield a wrong fault code, and a wrong attribution flag shows directly, one cycle after the request that exposes it. The stimulus is built so that each such error changes at least one output bit. The domain register is filled with the manager code everywhere except the selected field. Every table row flips a single condition against a granting baseline.

// File: rtl/apc_pkg.sv
package apc_pkg;

  // Access kinds as presented on reqKind
  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  // Fault codes on resFault
  localparam logic [2:0] FLT_NONE    = 3'd0;
  localparam logic [2:0] FLT_ALIGN   = 3'd1;
  localparam logic [2:0] FLT_DOMAIN  = 3'd2;
  localparam logic [2:0] FLT_PERM    = 3'd3;
  localparam logic [2:0] FLT_PF_UNC  = 3'd4;

  // Memory type encoding
  localparam logic [1:0] MEM_NORMAL = 2'd0;

  // Domain access field values
  localparam logic [1:0] DOM_NOACC   = 2'd0;
  localparam logic [1:0] DOM_CLIENT  = 2'd1;
  localparam logic [1:0] DOM_RSVD    = 2'd2;
  localparam logic [1:0] DOM_MANAGER = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic isFetch;
    logic isWrite;
  } strobe_t;

  // Verdict produced by the fault chain
  typedef struct packed {
    logic [2:0] code;
    logic       instSide;
    logic       stage2;
  } verdict_t;

endpackage

// File: rtl/apc_ctrl.sv
module apc_ctrl
  import apc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output strobe_t    strb,
  output logic       resValid
);

  // Access-kind decode; kind 3 behaves as a read
  always_comb begin
    strb.capture = reqValid;
    strb.isFetch = (reqKind == KIND_FETCH);
    strb.isWrite = (reqKind == KIND_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end

endmodule

// File: rtl/apc_datapath.sv
module apc_datapath
  import apc_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  parameter int ADDR_LSB_W  = 6,
  parameter int SIZE_W      = 3,
  localparam int DOM_IDX_W  = $clog2(NUM_DOMAINS),
  localparam int DACR_W     = 2 * NUM_DOMAINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic                  reqPriv,
  input  logic                  reqSecure,
  input  logic                  reqPrefetch,
  input  logic                  reqCacheMaint,
  input  logic                  reqPtWalk,
  input  logic [ADDR_LSB_W-1:0] reqAddrLow,
  input  logic [SIZE_W-1:0]     reqSizeLog2,
  input  logic [DOM_IDX_W-1:0]  entDomain,
  input  logic [2:0]            entAp,
  input  logic [1:0]            entHap,
  input  logic                  entXn,
  input  logic                  entPxn,
  input  logic [1:0]            entMemType,
  input  logic                  entNonCache,
  input  logic                  entLongFmt,
  input  logic                  entNonSecure,
  input  logic [DACR_W-1:0]     cfgDomainAccess,
  input  logic                  cfgWxn,
  input  logic                  cfgUwxn,
  input  logic                  cfgAfe,
  input  logic                  cfgSif,
  input  logic [1:0]            cfgLegacyRs,
  input  logic                  cfgPtwCheck,
  input  logic                  cfgStage2,
  output logic                  resGrant,
  output logic [2:0]            resFault,
  output logic                  resInstSide,
  output logic                  resStage2
);

  // ---------------- alignment mask ----------------
  logic [ADDR_LSB_W-1:0] sizeMask;
  logic                  unaligned;

  for (genvar b = 0; b < ADDR_LSB_W; b++) begin : g_mask
    assign sizeMask[b] = (32'(reqSizeLog2) > b);
  end

  assign unaligned = |(reqAddrLow & sizeMask);

  // ---------------- domain field select ----------------
  logic [1:0] domFields [NUM_DOMAINS];
  logic [1:0] domSel;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    assign domFields[d] = cfgDomainAccess[2*d +: 2];
  end

  assign domSel = domFields[entDomain];

  // ---------------- AP re-encoding ----------------
  logic [2:0] apRaw;
  logic [2:0] apEff;

  always_comb begin
    apRaw = entLongFmt ? {entAp[1:0], 1'b0} : entAp;
    apEff = (entLongFmt || cfgAfe) ? (apRaw | 3'b001) : apRaw;
  end

  // ---------------- AP abort and writability ----------------
  logic apAbort;
  logic writable;

  always_comb begin
    apAbort  = 1'b0;
    writable = 1'b1;
    if (!cfgStage2) begin
      unique case (apEff)
        3'd0: begin
          writable = 1'b0;
          unique case (cfgLegacyRs)
            2'd1:    apAbort = strb.isWrite || !reqPriv;
            2'd2:    apAbort = strb.isWrite;
            default: begin
              apAbort  = 1'b1;
              writable = 1'b1;
            end
          endcase
        end
        3'd1: apAbort = !reqPriv;
        3'd2: begin
          apAbort  = !reqPriv && strb.isWrite;
          writable = reqPriv;
        end
        3'd3: apAbort = 1'b0;
        3'd4: apAbort = 1'b1;
        3'd5: begin
          apAbort  = !reqPriv || strb.isWrite;
          writable = 1'b0;
        end
        default: begin
          apAbort  = strb.isWrite;
          writable = 1'b0;
        end
      endcase
    end
  end

  // ---------------- hypervisor permission and execute-never ----------------
  logic hapAbort;
  logic execNever;
  logic fetchFault;

  always_comb begin
    hapAbort   = strb.isWrite ? !entHap[1] : !entHap[0];
    execNever  = entXn
              || (writable && cfgWxn)
              || ((apEff == 3'd3) && cfgUwxn && reqPriv);
    fetchFault = strb.isFetch
              && (apAbort || execNever
                  || (entLongFmt && entPxn && reqPriv)
                  || (reqSecure && entNonSecure && cfgSif));
  end

  // ---------------- fault priority chain ----------------
  logic     memNormal;
  logic     ptwHit;
  logic     alignHit;
  logic     pfUncHit;
  verdict_t verdict;

  always_comb begin
    memNormal = (entMemType == MEM_NORMAL);
    ptwHit    = cfgStage2 && reqPtWalk && cfgPtwCheck && !memNormal;
    alignHit  = !strb.isFetch && !memNormal && unaligned;
    pfUncHit  = reqPrefetch && entNonCache;
  end

  always_comb begin
    verdict = '{code: FLT_NONE, instSide: 1'b0, stage2: 1'b0};
    if (reqCacheMaint) begin
      verdict.code = FLT_NONE;
    end else if (ptwHit) begin
      verdict = '{code: FLT_PERM, instSide: 1'b0, stage2: cfgStage2};
    end else if (alignHit) begin
      verdict = '{code: FLT_ALIGN, instSide: 1'b0, stage2: cfgStage2};
    end else if (pfUncHit) begin
      verdict = '{code: FLT_PF_UNC, instSide: 1'b1, stage2: cfgStage2};
    end else if (!entLongFmt && (domSel == DOM_NOACC || domSel == DOM_RSVD)) begin
      verdict = '{code: FLT_DOMAIN, instSide: strb.isFetch, stage2: cfgStage2};
    end else if (!entLongFmt && domSel == DOM_MANAGER) begin
      verdict.code = FLT_NONE;
    end else if (fetchFault) begin
      verdict = '{code: FLT_PERM, instSide: 1'b1, stage2: cfgStage2};
    end else if (apAbort || hapAbort) begin
      verdict = '{code: FLT_PERM, instSide: 1'b0, stage2: cfgStage2 || !apAbort};
    end
  end

  // ---------------- verdict register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resGrant    <= 1'b0;
      resFault    <= FLT_NONE;
      resInstSide <= 1'b0;
      resStage2   <= 1'b0;
    end else if (strb.capture) begin
      resGrant    <= (verdict.code == FLT_NONE);
      resFault    <= verdict.code;
      resInstSide <= verdict.instSide;
      resStage2   <= verdict.stage2;
    end
  end

endmodule

// File: rtl/sdesc_perm_check.sv
module sdesc_perm_check
  import apc_pkg::*;
#(
  parameter int NUM_DOMAINS = 16,
  parameter int ADDR_LSB_W  = 6,
  parameter int SIZE_W      = 3,
  localparam int DOM_IDX_W  = $clog2(NUM_DOMAINS),
  localparam int DACR_W     = 2 * NUM_DOMAINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [1:0]            reqKind,
  input  logic                  reqPriv,
  input  logic                  reqSecure,
  input  logic                  reqPrefetch,
  input  logic                  reqCacheMaint,
  input  logic                  reqPtWalk,
  input  logic [ADDR_LSB_W-1:0] reqAddrLow,
  input  logic [SIZE_W-1:0]     reqSizeLog2,
  input  logic [DOM_IDX_W-1:0]  entDomain,
  input  logic [2:0]            entAp,
  input  logic [1:0]            entHap,
  input  logic                  entXn,
  input  logic                  entPxn,
  input  logic [1:0]            entMemType,
  input  logic                  entNonCache,
  input  logic                  entLongFmt,
  input  logic                  entNonSecure,
  input  logic [DACR_W-1:0]     cfgDomainAccess,
  input  logic                  cfgWxn,
  input  logic                  cfgUwxn,
  input  logic                  cfgAfe,
  input  logic                  cfgSif,
  input  logic [1:0]            cfgLegacyRs,
  input  logic                  cfgPtwCheck,
  input  logic                  cfgStage2,
  output logic                  resValid,
  output logic                  resGrant,
  output logic [2:0]            resFault,
  output logic                  resInstSide,
  output logic                  resStage2
);

  strobe_t strb;

  apc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .strb     (strb),
    .resValid (resValid)
  );

  apc_datapath #(
    .NUM_DOMAINS (NUM_DOMAINS),
    .ADDR_LSB_W  (ADDR_LSB_W),
    .SIZE_W      (SIZE_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .reqPriv         (reqPriv),
    .reqSecure       (reqSecure),
    .reqPrefetch     (reqPrefetch),
    .reqCacheMaint   (reqCacheMaint),
    .reqPtWalk       (reqPtWalk),
    .reqAddrLow      (reqAddrLow),
    .reqSizeLog2     (reqSizeLog2),
    .entDomain       (entDomain),
    .entAp           (entAp),
    .entHap          (entHap),
    .entXn           (entXn),
    .entPxn          (entPxn),
    .entMemType      (entMemType),
    .entNonCache     (entNonCache),
    .entLongFmt      (entLongFmt),
    .entNonSecure    (entNonSecure),
    .cfgDomainAccess (cfgDomainAccess),
    .cfgWxn          (cfgWxn),
    .cfgUwxn         (cfgUwxn),
    .cfgAfe          (cfgAfe),
    .cfgSif          (cfgSif),
    .cfgLegacyRs     (cfgLegacyRs),
    .cfgPtwCheck     (cfgPtwCheck),
    .cfgStage2       (cfgStage2),
    .resGrant        (resGrant),
    .resFault        (resFault),
    .resInstSide     (resInstSide),
    .resStage2       (resStage2)
  );

endmodule

// File: rtl/apc_checker.sv
module apc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic       reqCacheMaint,
  input logic       reqPtWalk,
  input logic [1:0] entMemType,
  input logic       entLongFmt,
  input logic       cfgPtwCheck,
  input logic       cfgStage2,
  input logic       resValid,
  input logic       resGrant,
  input logic [2:0] resFault
);

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid); // R2

  AST_IDLE_DROPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid); // R2

  AST_IDLE_HOLDS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(resFault) && $stable(resGrant)); // R2

  AST_CMO_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqCacheMaint |=> resGrant && resFault == 3'd0); // R3

  AST_PTW_MEMTYPE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqCacheMaint && cfgStage2 && reqPtWalk && cfgPtwCheck
    && entMemType != 2'd0 |=> resFault == 3'd3); // R4

  AST_FETCH_NO_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'd2 |=> resFault != 3'd1); // R5

  AST_LONG_NO_DOMAIN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && entLongFmt |=> resFault != 3'd2); // R7

  AST_GRANT_MEANS_NOFAULT: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resGrant |-> resFault == 3'd0); // R11

endmodule

bind sdesc_perm_check apc_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqKind       (reqKind),
  .reqCacheMaint (reqCacheMaint),
  .reqPtWalk     (reqPtWalk),
  .entMemType    (entMemType),
  .entLongFmt    (entLongFmt),
  .cfgPtwCheck   (cfgPtwCheck),
  .cfgStage2     (cfgStage2),
  .resValid      (resValid),
  .resGrant      (resGrant),
  .resFault      (resFault)
);

// File: tb/sdesc_perm_check_tb.sv
`timescale 1ns/1ps
module sdesc_perm_check_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic        reqPriv, reqSecure, reqPrefetch, reqCacheMaint, reqPtWalk;
  logic [5:0]  reqAddrLow;
  logic [2:0]  reqSizeLog2;
  logic [3:0]  entDomain;
  logic [2:0]  entAp;
  logic [1:0]  entHap;
  logic        entXn, entPxn;
  logic [1:0]  entMemType;
  logic        entNonCache, entLongFmt, entNonSecure;
  logic [31:0] cfgDomainAccess;
  logic        cfgWxn, cfgUwxn, cfgAfe, cfgSif;
  logic [1:0]  cfgLegacyRs;
  logic        cfgPtwCheck, cfgStage2;
  logic        resValid, resGrant, resInstSide, resStage2;
  logic [2:0]  resFault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  sdesc_perm_check u_dut (.*);

  typedef struct packed {
    logic [1:0] kind;
    logic       priv;
    logic       lng;
    logic [2:0] ap;
    logic [1:0] hap;
    logic       xn;
    logic       pxn;
    logic [1:0] dom;
    logic [1:0] mem;
    logic       unal;
    logic       s2;
    logic [3:0] ctl;   // {wxn, uwxn, afe, sif}
    logic [1:0] sec;   // {secure, nonSecurePage}
    logic [2:0] misc;  // {prefetch, nonCache, cacheMaint}
    logic [1:0] ptw;   // {walk, ptwCheck}
    logic [1:0] rs;
    logic [2:0] eF;
    logic       eI;
    logic       eS;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [NV] = '{
    '{0,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},  // R8 base read
    '{1,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},  // R8 write ap3
    '{0,0,0,1,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},  // R8 ap1 user
    '{1,1,0,1,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},
    '{1,0,0,2,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},  // R8 ap2 user write
    '{0,0,0,2,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},
    '{1,1,0,5,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},
    '{0,1,0,5,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},
    '{1,1,0,7,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},
    '{0,0,0,6,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8},
    '{0,1,0,4,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},  // R8 ap4
    '{0,1,0,0,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},  // R8 ap0 rs0
    '{0,1,0,0,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,1, 0,0,0, 8},
    '{0,0,0,0,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,1, 3,0,0, 8},
    '{0,0,0,0,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,2, 0,0,0, 8},
    '{1,1,0,0,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,2, 3,0,0, 8},
    '{1,0,0,2,3,0,0,1,0,0,0,4'b0010,2'b00,3'b000,2'b00,0, 0,0,0, 8},  // R8 afe
    '{1,1,1,2,3,0,0,0,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,0, 8},  // R8 long ap->5
    '{1,0,1,1,3,0,0,0,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 7},  // R7 long skips domain
    '{0,1,0,3,3,0,0,0,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 2,0,0, 7},  // R7 no access
    '{2,1,0,3,3,0,0,0,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 2,1,0, 7},
    '{0,1,0,3,3,0,0,2,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 2,0,0, 7},
    '{2,0,0,1,3,1,0,3,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 7},  // R7 manager
    '{1,0,0,1,3,0,0,1,0,0,1,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 9},  // R9 s2 skips AP
    '{1,1,0,3,1,0,0,1,0,0,1,4'b0000,2'b00,3'b000,2'b00,0, 3,0,1, 9},
    '{0,1,0,3,2,0,0,1,0,0,1,4'b0000,2'b00,3'b000,2'b00,0, 3,0,1, 9},
    '{0,1,0,3,2,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,1,11},  // R11 hap only
    '{2,1,0,3,3,1,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,1,0,10},  // R10 xn
    '{2,1,0,3,3,0,0,1,0,0,0,4'b1000,2'b00,3'b000,2'b00,0, 3,1,0,10},
    '{2,1,0,7,3,0,0,1,0,0,0,4'b1000,2'b00,3'b000,2'b00,0, 0,0,0,10},
    '{2,1,0,3,3,0,0,1,0,0,0,4'b0100,2'b00,3'b000,2'b00,0, 3,1,0,10},
    '{2,0,0,3,3,0,0,1,0,0,0,4'b0100,2'b00,3'b000,2'b00,0, 0,0,0,10},
    '{2,1,1,1,3,0,1,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,1,0,10},
    '{2,0,1,1,3,0,1,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0,10},
    '{2,1,0,3,3,0,0,1,0,0,0,4'b0001,2'b11,3'b000,2'b00,0, 3,1,0,10},
    '{2,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b11,3'b000,2'b00,0, 0,0,0,10},
    '{2,1,0,3,2,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,0,1,11},  // R11 fetch hap
    '{2,0,0,1,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 3,1,0,10},
    '{0,1,0,3,3,0,0,1,1,1,0,4'b0000,2'b00,3'b000,2'b00,0, 1,0,0, 5},  // R5
    '{0,1,0,3,3,0,0,1,0,1,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 5},
    '{2,1,0,3,3,0,0,1,1,1,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 5},
    '{1,1,0,3,3,0,0,1,2,1,1,4'b0000,2'b00,3'b000,2'b00,0, 1,0,1, 5},
    '{0,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b110,2'b00,0, 4,1,0, 6},  // R6
    '{0,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b010,2'b00,0, 0,0,0, 6},
    '{0,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b100,2'b00,0, 0,0,0, 6},
    '{0,1,0,3,3,0,0,0,0,0,0,4'b0000,2'b00,3'b001,2'b00,0, 0,0,0, 3},  // R3
    '{0,1,0,3,3,0,0,1,1,0,1,4'b0000,2'b00,3'b001,2'b11,0, 0,0,0, 3},
    '{0,1,0,3,3,0,0,1,1,0,1,4'b0000,2'b00,3'b000,2'b11,0, 3,0,1, 4},  // R4
    '{0,1,0,3,3,0,0,1,0,0,1,4'b0000,2'b00,3'b000,2'b11,0, 0,0,0, 4},
    '{0,1,0,3,3,0,0,1,1,0,0,4'b0000,2'b00,3'b000,2'b11,0, 0,0,0, 4},
    '{0,1,0,3,3,0,0,1,1,0,1,4'b0000,2'b00,3'b000,2'b10,0, 0,0,0, 4},
    '{0,1,0,3,3,0,0,1,1,1,1,4'b0000,2'b00,3'b000,2'b11,0, 3,0,1,12},  // R12
    '{0,1,0,3,3,0,0,0,1,1,0,4'b0000,2'b00,3'b110,2'b00,0, 1,0,0,12},
    '{0,1,0,3,3,0,0,0,0,0,0,4'b0000,2'b00,3'b110,2'b00,0, 4,1,0,12},
    '{0,0,0,1,3,0,0,0,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 2,0,0,12},
    '{1,0,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 8}
  };

  task automatic drive(input vec_t v);
    reqValid        = 1'b1;
    reqKind         = v.kind;
    reqPriv         = v.priv;
    entLongFmt      = v.lng;
    entAp           = v.ap;
    entHap          = v.hap;
    entXn           = v.xn;
    entPxn          = v.pxn;
    entDomain       = 4'd5;
    cfgDomainAccess = 32'hFFFF_FFFF;
    cfgDomainAccess[11:10] = v.dom;
    entMemType      = v.mem;
    reqAddrLow      = v.unal ? 6'h02 : 6'h04;
    reqSizeLog2     = 3'd2;
    cfgStage2       = v.s2;
    {cfgWxn, cfgUwxn, cfgAfe, cfgSif}         = v.ctl;
    {reqSecure, entNonSecure}                 = v.sec;
    {reqPrefetch, entNonCache, reqCacheMaint} = v.misc;
    {reqPtWalk, cfgPtwCheck}                  = v.ptw;
    cfgLegacyRs     = v.rs;
  endtask

  function automatic vec_t baseVec();
    return '{0,1,0,3,3,0,0,1,0,0,0,4'b0000,2'b00,3'b000,2'b00,0, 0,0,0, 0};
  endfunction

  task automatic expectRes(input int rq, input logic v, input logic g,
                           input logic [2:0] f, input logic i, input logic s);
    logic [6:0] got;
    logic [6:0] exp;
    got = {resValid, resGrant, resFault, resInstSide, resStage2};
    exp = {v, g, f, i, s};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: {valid,grant,fault,inst,s2} got %b expected %b", rq, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(baseVec());
    reqValid = 1'b0;
    @(negedge clk);
    expectRes(1, 0, 0, 3'd0, 0, 0);   // R1 reset state
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectRes(1, 0, 0, 3'd0, 0, 0);   // R1 first cycle after reset

    // table walk, back-to-back requests
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      expectRes(int'(VECS[k].rq), 1, VECS[k].eF == 3'd0, VECS[k].eF, VECS[k].eI, VECS[k].eS);
    end

    // R2: idle cycle holds the last verdict and drops valid
    begin
      vec_t v;
      v = baseVec();
      v.dom = 2'd0;
      drive(v);
      @(negedge clk);
      expectRes(2, 1, 0, 3'd2, 0, 0);
      drive(baseVec());
      reqValid = 1'b0;
      @(negedge clk);
      expectRes(2, 0, 0, 3'd2, 0, 0);
      reqValid = 1'b1;
      @(negedge clk);
      expectRes(2, 1, 1, 3'd0, 0, 0);
    end

    // R5: alignment depends on access size
    begin
      vec_t v;
      v = baseVec();
      v.mem = 2'd1;
      drive(v);
      reqSizeLog2 = 3'd0; reqAddrLow = 6'h01;
      @(negedge clk);
      expectRes(5, 1, 1, 3'd0, 0, 0);
      drive(v);
      reqSizeLog2 = 3'd5; reqAddrLow = 6'h10;
      @(negedge clk);
      expectRes(5, 1, 0, 3'd1, 0, 0);
      drive(v);
      reqSizeLog2 = 3'd5; reqAddrLow = 6'h20;
      @(negedge clk);
      expectRes(5, 1, 1, 3'd0, 0, 0);
    end

    // R7: field position at the ends of the domain register
    drive(baseVec());
    entDomain = 4'd15;
    cfgDomainAccess = 32'h3FFF_FFFF;
    @(negedge clk);
    expectRes(7, 1, 0, 3'd2, 0, 0);
    drive(baseVec());
    entDomain = 4'd0;
    cfgDomainAccess = 32'hFFFF_FFFC;
    @(negedge clk);
    expectRes(7, 1, 0, 3'd2, 0, 0);

    // R8: kind 3 behaves as a read (ap2 user read granted, write would abort)
    begin
      vec_t v;
      v = baseVec();
      v.kind = 2'd3; v.priv = 1'b0; v.ap = 3'd2;
      drive(v);
      @(negedge clk);
      expectRes(8, 1, 1, 3'd0, 0, 0);
    end

    // R1: reset in the middle of operation clears the verdict
    begin
      vec_t v;
      v = baseVec();
      v.ap = 3'd4;
      drive(v);
      @(negedge clk);
      expectRes(8, 1, 0, 3'd3, 0, 0);
      rstN = 1'b0;
      @(negedge clk);
      expectRes(1, 0, 0, 3'd0, 0, 0);
      rstN = 1'b1;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule